// File: doc/BRIEF.md
# Soft-Decision Symbol Input Formatter

This block sits at the front of a rate-1/2 convolutional decoder. It takes 3-bit soft-decision code symbols and hands the decoder aligned G1/G2 pairs in a single internal confidence code. Symbols come either on two buses at once (parallel mode) or one at a time on a single bus (sequential mode). In sequential mode a slot strobe says whether the present symbol belongs to the G1 or the G2 slot.

Two input codes are accepted: offset binary, and an offset signed-magnitude code whose negative half runs in reverse order. Both are mapped onto offset binary, where all ones is the strongest "1" and all zeros is the strongest "0". Hard-decision data is supported by putting the data bit on the sign bit, tying the lower bits high and selecting the signed-magnitude code. Everything runs on one clock. A symbol-valid enable qualifies each input sample, and a one-cycle pair-valid pulse marks each completed pair.

Top module: `sdsym_fmt_top`

## Requirements
- R1: With `fmt_ob` high, each captured symbol is passed on unchanged (offset binary: 111 strongest one, 000 strongest zero).
- R2: With `fmt_ob` low, a symbol whose bit 2 is 1 is passed on unchanged. A symbol whose bit 2 is 0 maps as 000→011, 001→010, 010→001 and 011→000.
- R3: Hard-decision input (111 for a one, 011 for a zero, `fmt_ob` low) comes out as 111 and 000.
- R4: With `par_mode` high, a sample taken while `sym_vld` is high forms one pair: G1 comes from `sym_a` and G2 from `sym_b`. `pair_vld` is high for one cycle, in the cycle right after the sampling edge.
- R5: With `par_mode` low and `rate_sel` equal to 000, a valid sample with `g2_strobe` low is stored as G1. A valid sample with `g2_strobe` high is taken as G2 and completes the pair with the stored G1. `sym_b` is ignored, and samples with `sym_vld` low change nothing.
- R6: In sequential mode `pair_vld` rises two cycles later than in parallel mode, that is, three cycles after the edge that samples G2.
- R7: In sequential mode, a G2 that arrives with no stored G1 is dropped. A second G1 before any G2 replaces the first.
- R8: In sequential mode with `rate_sel` not equal to 000, `g2_strobe` is ignored. Valid symbols fill G1 and then G2 in turn, starting with G1 after reset and after each completed pair.
- R9: While `rst_n` is low at a clock edge, the stored G1, the pending-G1 state and all pairs in flight are cleared. No pair is emitted until a fresh G1 has been captured.
- R10: While `pair_vld` is low, `pair_g1` and `pair_g2` are 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_vld | input | 1 | Input sample qualifier |
| par_mode | input | 1 | 1: two-bus parallel input, 0: single-bus sequential input |
| fmt_ob | input | 1 | 1: offset binary, 0: offset signed-magnitude |
| rate_sel | input | 3 | Rate select; 000 enables the slot strobe |
| g2_strobe | input | 1 | Sequential mode: 1 marks the sample as G2 |
| sym_a | input | 3 | G1 symbol bus (also carries G2 in sequential mode) |
| sym_b | input | 3 | G2 symbol bus, parallel mode only |
| pair_g1 | output | 3 | G1 of the emitted pair, offset binary |
| pair_g2 | output | 3 | G2 of the emitted pair, offset binary |
| pair_vld | output | 1 | One-cycle pulse per emitted pair |

## Verification
All eight codes are swept in both numeric formats, with G2 set as the complement of G1. This separates a correct remap from a swapped bus or an inverted sign half. The hard-decision pair 111/011 is also sent in both orders. Sequential traffic uses a live value on the unused bus, gaps with the strobe toggling, orphan G2 samples and repeated G1 samples. These tell a dropped or overwritten symbol apart from a correctly held one, and a wrong latency shows up as a pulse in the wrong cycle. A non-zero rate code with the strobe held at a misleading level checks the alternating fill, and a reset between G1 and G2 checks that a half-built pair is discarded.

// File: rtl/sdsym_pkg.sv
// Shared definitions for the soft-decision symbol formatter.
// Assumes: 3-bit symbols and a 3-bit rate code by default.
package sdsym_pkg;
    localparam int unsigned DEF_SYM_W   = 3;
    localparam int unsigned DEF_RATE_W  = 3;
    localparam int unsigned DEF_SEQ_XTR = 2;

    // Numeric code of incoming symbols
    typedef enum logic {
        FMT_SM = 1'b0,
        FMT_OB = 1'b1
    } fmt_e;

    // Where the current input sample goes
    typedef enum logic [1:0] {
        ST_DROP = 2'd0,
        ST_G1   = 2'd1,
        ST_G2   = 2'd2,
        ST_PAR  = 2'd3
    } steer_e;
endpackage

// File: rtl/sdsym_conv.sv
// Maps one symbol from the selected input code onto offset binary.
// Assumes: the MSB is the sign in both codes; in signed-magnitude the
// negative half counts toward confidence, so its magnitude bits invert.
module sdsym_conv
    import sdsym_pkg::*;
#(
    parameter int unsigned SYM_W = DEF_SYM_W
) (
    input  logic             fmt_ob,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] sym_out
);
    localparam int unsigned MAG_W = SYM_W - 1;

    logic             sign_bit;
    logic [MAG_W-1:0] mag_bits;

    assign sign_bit = sym_in[SYM_W-1];
    assign mag_bits = sym_in[MAG_W-1:0];

    // Select pass-through or magnitude reversal for the negative half
    always_comb begin
        if (fmt_e'(fmt_ob) == FMT_OB || sign_bit) begin
            sym_out = sym_in;
        end else begin
            sym_out = {1'b0, ~mag_bits};
        end
    end
endmodule

// File: rtl/sdsym_pair.sv
// Steers converted symbols into G1/G2 slots and registers a pair event.
// Assumes: the mode inputs change only while no pair is in flight.
// Output ev_seq tags pairs built in sequential mode for the delay tap.
module sdsym_pair
    import sdsym_pkg::*;
#(
    parameter int unsigned SYM_W  = DEF_SYM_W,
    parameter int unsigned RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_vld,
    input  logic              par_mode,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              g2_strobe,
    input  logic [SYM_W-1:0]  cv_a,
    input  logic [SYM_W-1:0]  cv_b,
    output logic              ev_vld,
    output logic              ev_seq,
    output logic [SYM_W-1:0]  ev_g1,
    output logic [SYM_W-1:0]  ev_g2
);
    logic             pend;
    logic [SYM_W-1:0] hold_g1;
    logic             strobe_on;
    logic             want_g2;
    steer_e           steer;

    assign strobe_on = (rate_sel == '0);
    assign want_g2   = strobe_on ? g2_strobe : pend;

    // Decide the destination of the current sample
    always_comb begin
        if (!sym_vld) begin
            steer = ST_DROP;
        end else if (par_mode) begin
            steer = ST_PAR;
        end else if (!want_g2) begin
            steer = ST_G1;
        end else if (pend) begin
            steer = ST_G2;
        end else begin
            steer = ST_DROP;
        end
    end

    // Hold the pending G1 and its flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            hold_g1 <= '0;
        end else begin
            case (steer)
                ST_G1: begin
                    pend    <= 1'b1;
                    hold_g1 <= cv_a;
                end
                ST_G2, ST_PAR: pend <= 1'b0;
                default: ;
            endcase
        end
    end

    // Register a completed pair and its origin tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_vld <= 1'b0;
            ev_seq <= 1'b0;
            ev_g1  <= '0;
            ev_g2  <= '0;
        end else begin
            ev_vld <= 1'b0;
            if (steer == ST_PAR) begin
                ev_vld <= 1'b1;
                ev_seq <= 1'b0;
                ev_g1  <= cv_a;
                ev_g2  <= cv_b;
            end else if (steer == ST_G2) begin
                ev_vld <= 1'b1;
                ev_seq <= 1'b1;
                ev_g1  <= hold_g1;
                ev_g2  <= cv_a;
            end
        end
    end

    // R4: a parallel pair stems from a valid parallel sample
    p_par_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && !ev_seq) |-> $past(sym_vld && par_mode));

    // R7: a sequential pair needs a G1 stored beforehand
    p_seq_needs_g1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && ev_seq) |-> $past(pend));

    // R5: two sequential pairs can never be back to back
    p_seq_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && ev_seq) |=> !(ev_vld && ev_seq));

    // R7: a strobed G1 always leaves a pending G1
    p_g1_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && !par_mode && strobe_on && !g2_strobe) |=> pend);

    // R9: leaving reset finds nothing pending and nothing emitted
    p_fresh_after_reset_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> (!pend && !ev_vld));
endmodule

// File: rtl/sdsym_delay.sv
// Fixed-length valid/data delay line that equalises the sequential path.
// Assumes: DEPTH is small; zero depth gives a plain wire.
module sdsym_delay #(
    parameter int unsigned W     = 6,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign out_vld  = in_vld;
            assign out_data = in_data;
        end else begin : g_line
            logic [DEPTH-1:0] v_q;
            logic [W-1:0]     d_q [DEPTH];

            // First stage loads from the input
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[0] <= 1'b0;
                    d_q[0] <= '0;
                end else begin
                    v_q[0] <= in_vld;
                    d_q[0] <= in_vld ? in_data : '0;
                end
            end

            for (genvar i = 1; i < DEPTH; i++) begin : g_stage
                // Each later stage copies its predecessor
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q[i] <= 1'b0;
                        d_q[i] <= '0;
                    end else begin
                        v_q[i] <= v_q[i-1];
                        d_q[i] <= d_q[i-1];
                    end
                end
            end

            assign out_vld  = v_q[DEPTH-1];
            assign out_data = d_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/sdsym_fmt_top.sv
// Soft-decision symbol input formatter, top level.
// Converts both buses, assembles G1/G2 pairs and aligns the sequential
// path SEQ_XTR cycles behind the parallel path.
// Assumes: mode inputs change only while the pipeline is empty.
module sdsym_fmt_top
    import sdsym_pkg::*;
#(
    parameter int unsigned SYM_W   = DEF_SYM_W,
    parameter int unsigned RATE_W  = DEF_RATE_W,
    parameter int unsigned SEQ_XTR = DEF_SEQ_XTR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_vld,
    input  logic              par_mode,
    input  logic              fmt_ob,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              g2_strobe,
    input  logic [SYM_W-1:0]  sym_a,
    input  logic [SYM_W-1:0]  sym_b,
    output logic [SYM_W-1:0]  pair_g1,
    output logic [SYM_W-1:0]  pair_g2,
    output logic              pair_vld
);
    localparam int unsigned LANES  = 2;
    localparam int unsigned PAIR_W = 2 * SYM_W;

    logic [LANES-1:0][SYM_W-1:0] raw_sym;
    logic [LANES-1:0][SYM_W-1:0] cv_sym;

    logic              ev_vld;
    logic              ev_seq;
    logic [SYM_W-1:0]  ev_g1;
    logic [SYM_W-1:0]  ev_g2;
    logic              par_take;
    logic              seq_vld;
    logic [PAIR_W-1:0] seq_data;

    assign raw_sym[0] = sym_a;
    assign raw_sym[1] = sym_b;

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            sdsym_conv #(.SYM_W(SYM_W)) u_conv (
                .fmt_ob  (fmt_ob),
                .sym_in  (raw_sym[ln]),
                .sym_out (cv_sym[ln])
            );
        end
    endgenerate

    sdsym_pair #(.SYM_W(SYM_W), .RATE_W(RATE_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_vld   (sym_vld),
        .par_mode  (par_mode),
        .rate_sel  (rate_sel),
        .g2_strobe (g2_strobe),
        .cv_a      (cv_sym[0]),
        .cv_b      (cv_sym[1]),
        .ev_vld    (ev_vld),
        .ev_seq    (ev_seq),
        .ev_g1     (ev_g1),
        .ev_g2     (ev_g2)
    );

    sdsym_delay #(.W(PAIR_W), .DEPTH(SEQ_XTR)) u_seq_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (ev_vld & ev_seq),
        .in_data  ({ev_g1, ev_g2}),
        .out_vld  (seq_vld),
        .out_data (seq_data)
    );

    assign par_take = ev_vld & ~ev_seq;

    // Pick the active tap and force zeros when idle
    always_comb begin
        pair_vld = par_take | seq_vld;
        if (par_take) begin
            pair_g1 = ev_g1;
            pair_g2 = ev_g2;
        end else if (seq_vld) begin
            pair_g1 = seq_data[PAIR_W-1:SYM_W];
            pair_g2 = seq_data[SYM_W-1:0];
        end else begin
            pair_g1 = '0;
            pair_g2 = '0;
        end
    end

    // R6: the parallel and sequential taps never fire together
    p_one_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_take && seq_vld));

    // R10: idle outputs read as zero
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_vld |-> (pair_g1 == '0 && pair_g2 == '0));
endmodule

// File: tb/tb_sdsym_fmt_top.sv
`timescale 1ns/1ps
module tb_sdsym_fmt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_vld = 1'b0;
    logic       par_mode = 1'b1;
    logic       fmt_ob = 1'b1;
    logic [2:0] rate_sel = 3'b000;
    logic       g2_strobe = 1'b0;
    logic [2:0] sym_a = 3'd0;
    logic [2:0] sym_b = 3'd0;
    logic [2:0] pair_g1;
    logic [2:0] pair_g2;
    logic       pair_vld;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_tag = "R9";

    int    q_due[$];
    int    q_g1[$];
    int    q_g2[$];
    string q_tag[$];
    bit    m_pend = 1'b0;
    int    m_g1 = 0;

    sdsym_fmt_top dut (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .par_mode(par_mode),
        .fmt_ob(fmt_ob), .rate_sel(rate_sel), .g2_strobe(g2_strobe),
        .sym_a(sym_a), .sym_b(sym_b),
        .pair_g1(pair_g1), .pair_g2(pair_g2), .pair_vld(pair_vld)
    );

    always #2.5 clk = ~clk;

    // Expected offset-binary value of a symbol (R1, R2, R3)
    function automatic int ref_val(input int v, input bit ob);
        if (ob || v >= 4) return v;
        return 3 - v;
    endfunction

    // Reference model: advance one cycle at each rising edge
    always @(posedge clk) begin
        bit is_g2;
        int va;
        cyc = cyc + 1;
        if (!rst_n) begin
            m_pend = 1'b0;
            q_due.delete(); q_g1.delete(); q_g2.delete(); q_tag.delete();
        end else if (sym_vld) begin
            va = ref_val(int'(sym_a), fmt_ob);
            if (par_mode) begin
                q_due.push_back(cyc); q_g1.push_back(va);
                q_g2.push_back(ref_val(int'(sym_b), fmt_ob));
                q_tag.push_back(cur_tag);
                m_pend = 1'b0;
            end else begin
                is_g2 = (rate_sel == 3'b000) ? g2_strobe : m_pend;
                if (!is_g2) begin
                    m_g1 = va; m_pend = 1'b1;
                end else if (m_pend) begin
                    q_due.push_back(cyc + 2); q_g1.push_back(m_g1);
                    q_g2.push_back(va); q_tag.push_back(cur_tag);
                    m_pend = 1'b0;
                end
            end
        end
    end

    // Compare outputs with the model in the middle of each cycle
    always @(negedge clk) begin
        int    ev, e1, e2;
        string tg;
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            ev = 1; e1 = q_g1[0]; e2 = q_g2[0]; tg = q_tag[0];
            void'(q_due.pop_front()); void'(q_g1.pop_front());
            void'(q_g2.pop_front()); void'(q_tag.pop_front());
        end else begin
            ev = 0; e1 = 0; e2 = 0; tg = (cur_tag == "R9") ? "R9" : "R10";
        end
        checks++;
        if (int'(pair_vld) != ev || int'(pair_g1) != e1 || int'(pair_g2) != e2) begin
            errors++;
            $display("FAIL %s cycle %0d: actual vld=%0d g1=%0d g2=%0d expected vld=%0d g1=%0d g2=%0d",
                     tg, cyc, pair_vld, pair_g1, pair_g2, ev, e1, e2);
        end
    end

    task automatic drive(input bit v, input bit pm, input bit ob, input int rs,
                         input bit st, input int a, input int b);
        @(negedge clk);
        sym_vld = v; par_mode = pm; fmt_ob = ob; rate_sel = 3'(rs);
        g2_strobe = st; sym_a = 3'(a); sym_b = 3'(b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sym_vld = 1'b0;
            g2_strobe = ~g2_strobe;
            sym_a = sym_a + 3'd3;
            sym_b = sym_b + 3'd5;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected end before 20000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state, outputs idle
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 and R4: all offset-binary codes, G2 the complement
        cur_tag = "R1";
        for (int v = 0; v < 8; v++) drive(1, 1, 1, 0, 0, v, 7 - v);
        idle(3);

        // R2: all signed-magnitude codes
        cur_tag = "R2";
        for (int v = 0; v < 8; v++) drive(1, 1, 0, 0, 0, v, 7 - v);
        idle(3);

        // R3: hard-decision one and zero in both slots
        cur_tag = "R3";
        drive(1, 1, 0, 0, 0, 7, 3);
        drive(1, 1, 0, 0, 0, 3, 7);
        idle(3);

        // R4: parallel with gaps and distinct buses
        cur_tag = "R4";
        drive(1, 1, 1, 0, 0, 2, 5);
        drive(0, 1, 1, 0, 0, 6, 6);
        drive(1, 1, 1, 0, 1, 4, 1);
        idle(4);

        // R5: sequential pairs with the strobe, live noise on sym_b
        cur_tag = "R5";
        drive(1, 0, 1, 0, 0, 5, 2);
        drive(1, 0, 1, 0, 1, 1, 6);
        drive(0, 0, 1, 0, 0, 7, 7);
        drive(0, 0, 1, 0, 1, 0, 7);
        drive(1, 0, 0, 0, 0, 2, 4);
        drive(0, 0, 0, 0, 1, 6, 4);
        drive(1, 0, 0, 0, 1, 6, 1);
        idle(5);

        // R6: one sequential pair, latency checked by the cycle compare
        cur_tag = "R6";
        drive(1, 0, 1, 0, 0, 3, 0);
        drive(1, 0, 1, 0, 1, 4, 0);
        idle(5);

        // R7: orphan G2 dropped, second G1 replaces first
        cur_tag = "R7";
        drive(1, 0, 1, 0, 1, 6, 0);
        drive(1, 0, 1, 0, 0, 2, 0);
        drive(1, 0, 1, 0, 0, 6, 0);
        drive(1, 0, 1, 0, 1, 3, 0);
        drive(1, 0, 1, 0, 1, 5, 0);
        idle(5);

        // R8: non-zero rate code, strobe ignored, alternate fill
        cur_tag = "R8";
        drive(1, 0, 1, 4, 1, 1, 0);
        drive(1, 0, 1, 4, 0, 2, 0);
        drive(1, 0, 1, 4, 1, 3, 0);
        drive(0, 0, 1, 4, 1, 7, 0);
        drive(1, 0, 1, 4, 1, 4, 0);
        idle(5);

        // R9: reset between G1 and G2 discards the half pair
        cur_tag = "R9";
        drive(1, 0, 1, 0, 0, 6, 0);
        @(negedge clk); sym_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        drive(1, 0, 1, 0, 1, 2, 0);
        drive(1, 0, 1, 0, 0, 1, 0);
        drive(1, 0, 1, 0, 1, 7, 0);
        idle(6);

        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL R10: actual %0d pairs still expected, expected 0", q_due.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule